// File: doc/BRIEF.md
# Conversion and Readout Trigger Sequencer

This block paces a successive-approximation converter and a serial readout engine. A phase counter, reloaded every conversion period, produces the conversion-start pulse. The pulse is produced the same way whichever readout scheme is chosen. A second decision path tells the serial engine when the previous result may be shifted out. It gives a one-cycle readout trigger and a level that marks the span in which the transfer is allowed.

Two readout schemes are supported. In the busy-edge scheme the trigger follows a falling edge of the converter's busy line, after that line has been synchronised. In the timer scheme the busy line is ignored. The trigger is then placed a fixed guard interval after a conversion start, and only on every N-th conversion, so that an averaging converter can be read once per decimated result. In both schemes the readout span closes a guard interval before the next conversion start. A trigger that would land inside a guard zone is discarded. A trigger that comes while a readout is still in progress is suppressed and counted as an overrun. All settings are in clock cycles and take effect only at a period boundary.

Top module: `cnv_rdout_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the conversion pulse, trigger and span flag are low and the overrun count is zero.
- R2: With a latched period P (at least 2) and width W, the conversion pulse is high for phases 0 to W-1 of every P-cycle period. Phase 0 is the first cycle after the first clock edge following reset. A period below 2 keeps the block idle with the pulse low.
- R3: Changes to period, width, guard, decimation or scheme take effect at the start of the next period only. The period in progress completes unchanged.
- R4: In the timer scheme (scheme input 1), the trigger is high for one cycle, in phase G of those conversions whose index since reset is a multiple of N. The first conversion has index 0. A guard of 0 acts as 1, and a decimation of 0 acts as 1.
- R5: In the timer scheme, the busy input has no effect on any output.
- R6: In the busy-edge scheme (scheme input 0), a busy fall driven in cycle c gives a one-cycle trigger in cycle c+3. This holds when the busy line was high for at least two sampled cycles before the fall, and when the trigger is not suppressed or dropped. No trigger occurs without a busy fall.
- R7: The span flag rises together with an accepted trigger. It falls in phase P-G, or in the cycle after the done input is sampled high, whichever comes first. It is low whenever the conversion pulse rises.
- R8: A trigger event that arrives while the span flag is high produces no trigger and adds one to the overrun count. The count saturates at its maximum.
- R9: A trigger event whose trigger cycle would fall outside phases G to P-G-1 is dropped. No trigger is produced and the overrun count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_period | input | PER_W | Conversion period in cycles |
| cfg_pulse | input | PER_W | Conversion pulse width in cycles |
| cfg_guard | input | PER_W | Guard interval in cycles |
| cfg_decim | input | DEC_W | Conversions per readout in the timer scheme |
| cfg_zone | input | 1 | Readout scheme: 0 busy edge, 1 timer |
| busy_i | input | 1 | Converter busy line, asynchronous |
| rd_done_i | input | 1 | Readout finished, one cycle |
| cnv_o | output | 1 | Conversion-start pulse |
| rd_trig_o | output | 1 | Readout trigger, one cycle |
| rd_win_o | output | 1 | Readout span active |
| ovr_cnt_o | output | OVR_W | Saturating count of suppressed triggers |

## Verification
A wrong phase count or a missed reload shows at the conversion pin within one period. It appears as a pulse edge on the wrong cycle, and at most one period later the trigger slot of the timer scheme is also displaced. A decimation counter that is off appears only on conversions that should stay silent, so each sweep runs two full decimation cycles. A stuck span flag shows as an overrun increment on the next busy fall, or as the span still being high at a conversion start. A synchroniser of the wrong depth moves every busy-edge trigger by exactly one cycle.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

    typedef enum logic {
        ZONE_BUSY  = 1'b0,
        ZONE_TIMER = 1'b1
    } zone_e;

endpackage

// File: rtl/cnv_busy_sync.sv
module cnv_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic fall_o
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its one-cycle delay
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], busy_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.sh[STAGES] & ~st_q.sh[STAGES-1];

endmodule

// File: rtl/cnv_phase_gen.sv
module cnv_phase_gen
    import cnv_seq_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int DEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [PER_W-1:0] cfg_pulse,
    input  logic [PER_W-1:0] cfg_guard,
    input  logic [DEC_W-1:0] cfg_decim,
    input  logic             cfg_zone,
    output logic             cnv_o,
    output zone_e            zone_o,
    output logic             trig_pt_o,
    output logic             open_ok_o,
    output logic             close_pt_o
);
    localparam int EXT_W = PER_W + 2;
    localparam int DCX_W = DEC_W + 1;

    typedef struct packed {
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] pw;
        logic [PER_W-1:0] guard;
        logic [DEC_W-1:0] decim;
        zone_e            zone;
        logic [PER_W-1:0] ph;
        logic [DEC_W-1:0] dec;
    } phase_st_t;

    phase_st_t st_d, st_q;

    logic             run;
    logic             bnd;
    logic [PER_W-1:0] guard_new;
    logic [DEC_W-1:0] decim_new;
    logic [DCX_W-1:0] dec_inc;
    logic [EXT_W-1:0] ph_x, g_x, per_x;

    always_comb begin
        run       = (st_q.per >= PER_W'(2));
        bnd       = !run || (st_q.ph == st_q.per - PER_W'(1));
        guard_new = (cfg_guard == '0) ? PER_W'(1) : cfg_guard;
        decim_new = (cfg_decim == '0) ? DEC_W'(1) : cfg_decim;
        dec_inc   = {1'b0, st_q.dec} + DCX_W'(1);

        st_d = st_q;
        if (bnd) begin
            st_d.per   = cfg_period;
            st_d.pw    = cfg_pulse;
            st_d.guard = guard_new;
            st_d.decim = decim_new;
            st_d.zone  = zone_e'(cfg_zone);
            st_d.ph    = '0;
            if (!run || dec_inc >= {1'b0, decim_new}) st_d.dec = '0;
            else                                      st_d.dec = dec_inc[DEC_W-1:0];
        end else begin
            st_d.ph = st_q.ph + PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.zone <= ZONE_BUSY;
        end else begin
            st_q <= st_d;
        end
    end

    // decoded phase points; each is acted on one edge later by the gate
    always_comb begin
        ph_x       = EXT_W'(st_q.ph);
        g_x        = EXT_W'(st_q.guard);
        per_x      = EXT_W'(st_q.per);
        cnv_o      = run && (st_q.ph < st_q.pw);
        zone_o     = st_q.zone;
        trig_pt_o  = run && (st_q.dec == '0) && (ph_x + EXT_W'(1) == g_x);
        open_ok_o  = run && (ph_x + EXT_W'(1) >= g_x) && (ph_x + g_x + EXT_W'(2) <= per_x);
        close_pt_o = run && (ph_x + g_x + EXT_W'(1) == per_x);
    end

endmodule

// File: rtl/cnv_rd_gate.sv
module cnv_rd_gate
    import cnv_seq_pkg::*;
#(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  zone_e            zone_i,
    input  logic             trig_pt_i,
    input  logic             busy_fall_i,
    input  logic             open_ok_i,
    input  logic             close_pt_i,
    input  logic             rd_done_i,
    output logic             rd_trig_o,
    output logic             rd_win_o,
    output logic [OVR_W-1:0] ovr_cnt_o
);
    typedef struct packed {
        logic             trig;
        logic             win;
        logic [OVR_W-1:0] ovr;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic ev;
    logic ev_ok;
    logic accept;

    always_comb begin
        ev     = (zone_i == ZONE_BUSY) ? busy_fall_i : trig_pt_i;
        ev_ok  = ev && open_ok_i;
        accept = ev_ok && !st_q.win;

        st_d      = st_q;
        st_d.trig = accept;
        if (accept)                                    st_d.win = 1'b1;
        else if (st_q.win && (rd_done_i || close_pt_i)) st_d.win = 1'b0;

        if (ev_ok && st_q.win && (st_q.ovr != '1))
            st_d.ovr = st_q.ovr + OVR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_trig_o = st_q.trig;
    assign rd_win_o  = st_q.win;
    assign ovr_cnt_o = st_q.ovr;

endmodule

// File: rtl/cnv_rdout_seq.sv
module cnv_rdout_seq
    import cnv_seq_pkg::*;
#(
    parameter int PER_W     = 16,
    parameter int DEC_W     = 8,
    parameter int OVR_W     = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [PER_W-1:0] cfg_pulse,
    input  logic [PER_W-1:0] cfg_guard,
    input  logic [DEC_W-1:0] cfg_decim,
    input  logic             cfg_zone,
    input  logic             busy_i,
    input  logic             rd_done_i,
    output logic             cnv_o,
    output logic             rd_trig_o,
    output logic             rd_win_o,
    output logic [OVR_W-1:0] ovr_cnt_o
);
    zone_e zone;
    logic  trig_pt;
    logic  open_ok;
    logic  close_pt;
    logic  busy_fall;

    cnv_phase_gen #(
        .PER_W (PER_W),
        .DEC_W (DEC_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .cfg_pulse  (cfg_pulse),
        .cfg_guard  (cfg_guard),
        .cfg_decim  (cfg_decim),
        .cfg_zone   (cfg_zone),
        .cnv_o      (cnv_o),
        .zone_o     (zone),
        .trig_pt_o  (trig_pt),
        .open_ok_o  (open_ok),
        .close_pt_o (close_pt)
    );

    cnv_busy_sync #(
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .fall_o (busy_fall)
    );

    cnv_rd_gate #(
        .OVR_W (OVR_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .zone_i      (zone),
        .trig_pt_i   (trig_pt),
        .busy_fall_i (busy_fall),
        .open_ok_i   (open_ok),
        .close_pt_i  (close_pt),
        .rd_done_i   (rd_done_i),
        .rd_trig_o   (rd_trig_o),
        .rd_win_o    (rd_win_o),
        .ovr_cnt_o   (ovr_cnt_o)
    );

endmodule

// File: rtl/cnv_rdout_seq_chk.sv
module cnv_rdout_seq_chk #(
    parameter int OVR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_done_i,
    input logic             cnv_o,
    input logic             rd_trig_o,
    input logic             rd_win_o,
    input logic [OVR_W-1:0] ovr_cnt_o
);
    assert_trig_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_trig_o |-> rd_win_o);

    assert_win_opens_on_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_win_o) |-> rd_trig_o);

    assert_win_low_at_cnv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> !rd_win_o);

    assert_done_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win_o && rd_done_i) |=> !rd_win_o);

    assert_trig_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_trig_o |=> !rd_trig_o);

    assert_ovr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_cnt_o != $past(ovr_cnt_o)) |-> (ovr_cnt_o == $past(ovr_cnt_o) + OVR_W'(1)));

    assert_ovr_no_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_cnt_o != $past(ovr_cnt_o)) |-> !rd_trig_o);

endmodule

bind cnv_rdout_seq cnv_rdout_seq_chk #(.OVR_W(OVR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_done_i (rd_done_i),
    .cnv_o     (cnv_o),
    .rd_trig_o (rd_trig_o),
    .rd_win_o  (rd_win_o),
    .ovr_cnt_o (ovr_cnt_o)
);

// File: tb/sim_cnv_rdout_seq.sv
`timescale 1ns/1ps
module sim_cnv_rdout_seq;
    localparam int PER_W = 12;
    localparam int DEC_W = 4;
    localparam int OVR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PER_W-1:0] cfg_period = '0;
    logic [PER_W-1:0] cfg_pulse = '0;
    logic [PER_W-1:0] cfg_guard = '0;
    logic [DEC_W-1:0] cfg_decim = '0;
    logic             cfg_zone = 1'b0;
    logic             busy_i = 1'b0;
    logic             rd_done_i = 1'b0;
    logic             cnv_o;
    logic             rd_trig_o;
    logic             rd_win_o;
    logic [OVR_W-1:0] ovr_cnt_o;

    int nvec = 0;
    int nerr = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    cnv_rdout_seq #(.PER_W(PER_W), .DEC_W(DEC_W), .OVR_W(OVR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_pulse(cfg_pulse),
        .cfg_guard(cfg_guard), .cfg_decim(cfg_decim), .cfg_zone(cfg_zone),
        .busy_i(busy_i), .rd_done_i(rd_done_i), .cnv_o(cnv_o), .rd_trig_o(rd_trig_o),
        .rd_win_o(rd_win_o), .ovr_cnt_o(ovr_cnt_o)
    );

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    // reset, apply config, release at a falling edge: the caller is then in cycle 0
    task automatic start(int p, int w, int g, int n, bit z);
        rst_n = 1'b0; busy_i = 1'b0; rd_done_i = 1'b0;
        cfg_period = PER_W'(p); cfg_pulse = PER_W'(w); cfg_guard = PER_W'(g);
        cfg_decim = DEC_W'(n); cfg_zone = z;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 cnv in reset", int'(cnv_o), 0);
        chk("R1 win in reset", int'(rd_win_o), 0);
        rst_n = 1'b1;
        chk("R1 trig", int'(rd_trig_o), 0);
        chk("R1 ovr", int'(ovr_cnt_o), 0);
    endtask

    initial begin
        #1_500_000;
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // timer-scheme sweep with busy toggling (R2 R4 R5 R7)
        for (int p = 4; p <= 9; p++) begin
            for (int w = 1; w < p; w++) begin
                for (int g = 0; g <= (p - 1) / 2; g++) begin
                    for (int n = 0; n <= 3; n++) begin
                        int ge, ne;
                        ge = (g == 0) ? 1 : g;
                        ne = (n == 0) ? 1 : n;
                        start(p, w, g, n, 1'b1);
                        for (int c = 1; c <= p * ne * 2 + 2; c++) begin
                            int ph, k;
                            bit sel;
                            @(negedge clk);
                            ph  = (c - 1) % p;
                            k   = (c - 1) / p;
                            sel = (k % ne) == 0;
                            chk("R2 cnv", int'(cnv_o), int'(ph < w));
                            chk("R4 R5 trig", int'(rd_trig_o), int'(sel && ph == ge));
                            chk("R7 win", int'(rd_win_o), int'(sel && ph >= ge && ph <= p - ge - 1));
                            chk("R5 ovr", int'(ovr_cnt_o), 0);
                            busy_i = (c % 3) == 0;
                        end
                    end
                end
            end
        end

        // idle when the period is below 2 (R2)
        for (int p = 0; p <= 1; p++) begin
            start(p, 1, 1, 1, 1'b1);
            for (int c = 1; c <= 12; c++) begin
                @(negedge clk);
                chk("R2 idle cnv", int'(cnv_o), 0);
                chk("R2 idle trig", int'(rd_trig_o), 0);
            end
        end

        // configuration latched only at the period boundary (R3)
        start(6, 2, 1, 1, 1'b1);
        for (int c = 1; c <= 16; c++) begin
            int ec, et;
            @(negedge clk);
            if (c < 7) begin
                ec = int'(((c - 1) % 6) < 2);
                et = int'(((c - 1) % 6) == 1);
            end else begin
                ec = int'(((c - 7) % 4) < 1);
                et = int'(((c - 7) % 4) == 1);
            end
            chk("R3 cnv", int'(cnv_o), ec);
            chk("R3 trig", int'(rd_trig_o), et);
            if (c == 3) begin
                cfg_period = PER_W'(4);
                cfg_pulse  = PER_W'(1);
            end
        end

        // busy-edge scheme: P=30 W=3 G=2 (R6 R7 R8 R9)
        start(30, 3, 2, 1, 1'b0);
        for (int c = 1; c <= 95; c++) begin
            @(negedge clk);
            case (c)
                10: chk("R6 trig before latency", int'(rd_trig_o), 0);
                11: begin
                    chk("R6 trig", int'(rd_trig_o), 1);
                    chk("R7 win opens", int'(rd_win_o), 1);
                end
                12: chk("R6 single pulse", int'(rd_trig_o), 0);
                17: chk("R8 ovr before", int'(ovr_cnt_o), 0);
                18: begin
                    chk("R8 suppressed trig", int'(rd_trig_o), 0);
                    chk("R8 ovr", int'(ovr_cnt_o), 1);
                end
                28: chk("R7 win last", int'(rd_win_o), 1);
                29: chk("R7 win deadline", int'(rd_win_o), 0);
                41: chk("R6 trig period 2", int'(rd_trig_o), 1);
                45: chk("R7 win before done", int'(rd_win_o), 1);
                46: chk("R7 win after done", int'(rd_win_o), 0);
                53: begin
                    chk("R6 trig after done", int'(rd_trig_o), 1);
                    chk("R8 ovr kept", int'(ovr_cnt_o), 1);
                end
                63: chk("R6 no busy no trig", int'(rd_trig_o), 0);
                89: begin
                    chk("R9 guard drop trig", int'(rd_trig_o), 0);
                    chk("R9 guard drop win", int'(rd_win_o), 0);
                end
                90: chk("R9 guard drop ovr", int'(ovr_cnt_o), 1);
                default: ;
            endcase
            if (c == 1 || c == 12 || c == 35 || c == 47 || c == 80) busy_i = 1'b1;
            if (c == 8 || c == 15 || c == 38 || c == 50 || c == 86) busy_i = 1'b0;
            rd_done_i = (c == 45);
        end

        // overrun saturation (R8)
        start(200, 1, 1, 1, 1'b0);
        for (int c = 1; c <= 200; c++) begin
            @(negedge clk);
            if (c == 150) chk("R8 saturated", int'(ovr_cnt_o), 15);
            if (c == 200) chk("R8 held at max", int'(ovr_cnt_o), 15);
            busy_i = ((c / 3) % 2) == 1;
        end

        finish_run();
    end

endmodule